// File: doc/BRIEF.md
# Doubleword Register-Pair Load Unit

This unit carries out one doubleword load for a 32-bit load/store datapath. On a start strobe it decodes the instruction word it is given. It tests the instruction's condition against the N, Z, C and V flags. It then forms an effective address from a base register and an offset, and checks that address for alignment. If every check passes, it reads two consecutive words from memory through a request/ready port. The two words go to an even/odd destination register pair, and the base register can be updated.

The register file stays outside the unit. The unit names the base and index registers on two combinational select outputs and reads their values back in the same cycle. Results are handed back in a single completion cycle. In that cycle `done` pulses, `result` gives the outcome, and the write strobes for the register pair and for the base register are valid together. The outcome is one of: success, condition skip, alignment fault, memory abort, or illegal encoding.

Top module: `dword_pair_load`

## Requirements
- R1: `claim` is high exactly when instr[27:25]=000, instr[20]=0 and instr[7:4]=1101. A start with a word that does not match completes with result 4 (illegal), makes no memory request and writes no register.
- R2: A matching word whose destination field instr[15:12] is odd, or equals 14, also completes with result 4 and makes no memory request. This check takes priority over the condition test.
- R3: instr[31:28] selects the condition, with flags given as nzcv={N,Z,C,V}. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always. A failing condition completes with result 1 (skip), with no memory request and no write.
- R4: The offset source depends on instr[22]. When it is 1, the offset is the zero-extended byte {instr[11:8], instr[3:0]}. When it is 0, the offset is the value of the register named by instr[3:0]. instr[23]=1 adds the offset to the base register (instr[19:16]), and instr[23]=0 subtracts it.
- R5: With instr[24]=1 the memory access uses the offset address. With instr[24]=0 it uses the unmodified base.
- R6: On success, the base register is written with the offset address when instr[24]=0, or when instr[24]=1 and instr[21]=1. Otherwise it is not written.
- R7: With `align_en` high, an access address whose bits[1:0] are not 00 completes with result 2 (alignment fault) before any memory request. With `align_en` low, alignment is not checked.
- R8: With `align_en` and `dw_strict` both high, an access address with bit 2 set also gives result 2. `dw_strict` has no effect while `align_en` is low.
- R9: The first word is read at the access address and goes to register `pair_sel`. The second word is read at the access address plus 4 and goes to register `pair_sel`+1. Both are committed in the completion cycle.
- R10: `mem_err` on either read completes with result 3 (abort), and neither the pair nor the base register is written. An abort on the second read follows exactly one completed read.
- R11: `mem_req` stays high with `mem_addr` unchanged until `mem_ready` is seen. Any response latency of one cycle or more is accepted.
- R12: `done` is a one-cycle pulse, after which `busy` is low. A start while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe, taken only while idle |
| instr | input | 32 | Instruction word |
| nzcv | input | 4 | Condition flags {N,Z,C,V} |
| align_en | input | 1 | Enables the word alignment check |
| dw_strict | input | 1 | Additionally requires address bit 2 clear |
| claim | output | 1 | Instruction word has the doubleword-load pattern |
| busy | output | 1 | An instruction is in progress |
| rf_base_sel | output | 4 | Base register select |
| rf_base_data | input | 32 | Base register value |
| rf_index_sel | output | 4 | Index register select |
| rf_index_data | input | 32 | Index register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ready | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read failed (with mem_ready) |
| done | output | 1 | Completion pulse |
| result | output | 3 | 0 ok, 1 skip, 2 align, 3 abort, 4 illegal |
| pair_we | output | 1 | Write the register pair |
| pair_sel | output | 4 | Even destination register |
| pair_lo | output | 32 | Word for pair_sel |
| pair_hi | output | 32 | Word for pair_sel+1 |
| base_we | output | 1 | Write the base register |
| base_sel | output | 4 | Base register to write |
| base_data | output | 32 | Updated base value |

## Verification
The hardest case to reach is an abort on the second read, after the first read has already returned good data. That first word sits inside the unit and must never reach the register pair. The bench reaches this case by placing a base value just below the faulting region of its memory model, so the first address is good and the address plus 4 faults. It then checks that two reads happened with no write. A start pulsed while an instruction is waiting on a slow memory response is also driven. The bench checks that this second start leaves the result unchanged.

// File: rtl/dld_pkg.sv
package dld_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_SKIP    = 3'd1,
    RES_ALIGN   = 3'd2,
    RES_ABORT   = 3'd3,
    RES_ILLEGAL = 3'd4
  } dld_res_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2,
    ST_FIN   = 2'd3
  } dld_state_e;
endpackage

// File: rtl/dld_rst_sync.sv
module dld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/dld_cond.sv
module dld_cond (
  input  logic [3:0] code,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v, base;

  assign {n, z, c, v} = nzcv;

  // Codes come in pairs: even code tests a flag term, odd code its inverse.
  always_comb begin
    case (code[3:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c & ~z;
      3'd5:    base = (n == v);
      3'd6:    base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    pass = (code[3:1] == 3'd7) ? 1'b1 : (base ^ code[0]);
  end
endmodule

// File: rtl/dld_decode.sv
module dld_decode #(
  parameter int DW   = 32,
  parameter int RIW  = 4,
  parameter int OFFW = 8
) (
  input  logic [27:0]   instr,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] index_val,
  input  logic          align_en,
  input  logic          dw_strict,
  output logic          claim,
  output logic          legal,
  output logic [RIW-1:0] dest,
  output logic [RIW-1:0] base_reg,
  output logic [DW-1:0] acc_addr,
  output logic [DW-1:0] wb_addr,
  output logic          wb_en,
  output logic          misaligned
);
  localparam int HALF = OFFW / 2;
  localparam logic [RIW-1:0] LINK_REG = RIW'(14);

  logic          pre, up, imm, wbit;
  logic [DW-1:0] offset;

  assign pre  = instr[24];
  assign up   = instr[23];
  assign imm  = instr[22];
  assign wbit = instr[21];
  assign base_reg = instr[19:16];
  assign dest     = instr[15:12];

  assign claim = (instr[27:25] == 3'b000) && !instr[20] && (instr[7:4] == 4'b1101);
  assign legal = claim && !dest[0] && (dest != LINK_REG);

  assign offset = imm ? {{(DW-OFFW){1'b0}}, instr[8 +: HALF], instr[0 +: HALF]}
                      : index_val;

  assign wb_addr  = up ? (base_val + offset) : (base_val - offset);
  assign acc_addr = pre ? wb_addr : base_val;
  assign wb_en    = !pre || wbit;

  assign misaligned = align_en && ((acc_addr[1:0] != 2'b00) || (dw_strict && acc_addr[2]));
endmodule

// File: rtl/dld_seq.sv
module dld_seq
  import dld_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           legal,
  input  logic           cond_pass,
  input  logic           misaligned,
  input  logic           wb_en_in,
  input  logic [RIW-1:0] dest_in,
  input  logic [RIW-1:0] base_in,
  input  logic [DW-1:0]  acc_in,
  input  logic [DW-1:0]  wb_addr_in,
  output logic           busy,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic           mem_err,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic [2:0]     result,
  output logic           pair_we,
  output logic [RIW-1:0] pair_sel,
  output logic [DW-1:0]  pair_lo,
  output logic [DW-1:0]  pair_hi,
  output logic           base_we,
  output logic [RIW-1:0] base_sel,
  output logic [DW-1:0]  base_data
);
  localparam int BEAT_BYTES = DW / 8;

  dld_state_e     state_q, state_d;
  dld_res_e       res_q, res_d;
  logic [DW-1:0]  addr_q, lo_q, hi_q, wbaddr_q;
  logic [RIW-1:0] dest_q, base_q;
  logic           wben_q;
  logic           accept, beat_done, beat_ok, beat_bad;

  assign accept    = (state_q == ST_IDLE) && start;
  assign beat_done = mem_req && mem_ready;
  assign beat_ok   = beat_done && !mem_err;
  assign beat_bad  = beat_done && mem_err;

  // Next-state and outcome selection
  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: if (start) begin
        if (!legal) begin
          state_d = ST_FIN; res_d = RES_ILLEGAL;
        end else if (!cond_pass) begin
          state_d = ST_FIN; res_d = RES_SKIP;
        end else if (misaligned) begin
          state_d = ST_FIN; res_d = RES_ALIGN;
        end else begin
          state_d = ST_BEAT0; res_d = RES_OK;
        end
      end
      ST_BEAT0: if (beat_bad) begin
        state_d = ST_FIN; res_d = RES_ABORT;
      end else if (beat_ok) begin
        state_d = ST_BEAT1;
      end
      ST_BEAT1: if (beat_bad) begin
        state_d = ST_FIN; res_d = RES_ABORT;
      end else if (beat_ok) begin
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  // Datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q   <= acc_in;
      wbaddr_q <= wb_addr_in;
      dest_q   <= dest_in;
      base_q   <= base_in;
      wben_q   <= wb_en_in;
    end else if ((state_q == ST_BEAT0) && beat_ok) begin
      addr_q   <= addr_q + DW'(BEAT_BYTES);
    end
    if ((state_q == ST_BEAT0) && beat_ok) lo_q <= mem_rdata;
    if ((state_q == ST_BEAT1) && beat_ok) hi_q <= mem_rdata;
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign mem_addr  = addr_q;
  assign done      = (state_q == ST_FIN);
  assign result    = res_q;
  assign pair_we   = done && (res_q == RES_OK);
  assign pair_sel  = dest_q;
  assign pair_lo   = lo_q;
  assign pair_hi   = hi_q;
  assign base_we   = pair_we && wben_q;
  assign base_sel  = base_q;
  assign base_data = wbaddr_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  assert_second_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BEAT0) && beat_ok |=> mem_req && (mem_addr == $past(mem_addr) + DW'(BEAT_BYTES)));

  assert_abort_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_bad |=> done && !pair_we && !base_we);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

// File: rtl/dword_pair_load.sv
module dword_pair_load
  import dld_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [31:0]    instr,
  input  logic [3:0]     nzcv,
  input  logic           align_en,
  input  logic           dw_strict,
  output logic           claim,
  output logic           busy,
  output logic [RIW-1:0] rf_base_sel,
  input  logic [DW-1:0]  rf_base_data,
  output logic [RIW-1:0] rf_index_sel,
  input  logic [DW-1:0]  rf_index_data,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_err,
  output logic           done,
  output logic [2:0]     result,
  output logic           pair_we,
  output logic [RIW-1:0] pair_sel,
  output logic [DW-1:0]  pair_lo,
  output logic [DW-1:0]  pair_hi,
  output logic           base_we,
  output logic [RIW-1:0] base_sel,
  output logic [DW-1:0]  base_data
);
  logic           rst_s_n, legal, pass, misaligned, wb_en;
  logic [RIW-1:0] dest, base_reg;
  logic [DW-1:0]  acc_addr, wb_addr;

  dld_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  dld_cond u_cond (.code(instr[31:28]), .nzcv(nzcv), .pass(pass));

  dld_decode #(.DW(DW), .RIW(RIW)) u_dec (
    .instr(instr[27:0]), .base_val(rf_base_data), .index_val(rf_index_data),
    .align_en(align_en), .dw_strict(dw_strict), .claim(claim), .legal(legal),
    .dest(dest), .base_reg(base_reg), .acc_addr(acc_addr), .wb_addr(wb_addr),
    .wb_en(wb_en), .misaligned(misaligned));

  assign rf_base_sel  = base_reg;
  assign rf_index_sel = instr[3:0];

  dld_seq #(.DW(DW), .RIW(RIW)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .start(start), .legal(legal), .cond_pass(pass),
    .misaligned(misaligned), .wb_en_in(wb_en), .dest_in(dest), .base_in(base_reg),
    .acc_in(acc_addr), .wb_addr_in(wb_addr), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .done(done), .result(result), .pair_we(pair_we),
    .pair_sel(pair_sel), .pair_lo(pair_lo), .pair_hi(pair_hi), .base_we(base_we),
    .base_sel(base_sel), .base_data(base_data));

  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    start && !busy && legal && !pass |=> done && !mem_req && (result == 3'd1));

  assert_align_quiet_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    start && !busy && legal && pass && misaligned |=> done && !mem_req && (result == 3'd2));

  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    start && !busy && !legal |=> done && !mem_req && (result == 3'd4));
endmodule

// File: tb/sim_dword_pair_load.sv
module sim_dword_pair_load;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [3:0]  nzcv = 4'h0;
  logic        align_en = 1'b0, dw_strict = 1'b0;
  logic        claim, busy, mem_req, done, pair_we, base_we;
  logic [3:0]  rf_base_sel, rf_index_sel, pair_sel, base_sel;
  logic [31:0] rf_base_data, rf_index_data, mem_addr, pair_lo, pair_hi, base_data;
  logic [2:0]  result;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'h0;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, beats = 0, beats_mark = 0;
  logic [31:0] rf [16];

  typedef struct {
    int res; int nbeats; bit pwe; logic [3:0] psel; logic [31:0] lo, hi;
    bit bwe; logic [3:0] bsel; logic [31:0] bdata;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  always #10 clk = ~clk;  // 50 MHz

  assign rf_base_data  = rf[rf_base_sel];
  assign rf_index_data = rf[rf_index_sel];

  dword_pair_load u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .nzcv(nzcv),
    .align_en(align_en), .dw_strict(dw_strict), .claim(claim), .busy(busy),
    .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
    .rf_index_sel(rf_index_sel), .rf_index_data(rf_index_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .done(done), .result(result),
    .pair_we(pair_we), .pair_sel(pair_sel), .pair_lo(pair_lo), .pair_hi(pair_hi),
    .base_we(base_we), .base_sel(base_sel), .base_data(base_data));

  function automatic logic [31:0] mdata(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_00C3;
  endfunction
  function automatic bit merr(logic [31:0] a);
    return a[31:28] == 4'hF;
  endfunction
  function automatic bit cpass(logic [3:0] c, logic [3:0] f);
    bit n, z, cc, v;
    {n, z, cc, v} = f;
    case (c)
      4'd0: return z;            4'd1: return !z;
      4'd2: return cc;           4'd3: return !cc;
      4'd4: return n;            4'd5: return !n;
      4'd6: return v;            4'd7: return !v;
      4'd8: return cc && !z;     4'd9: return !cc || z;
      4'd10: return n == v;      4'd11: return n != v;
      4'd12: return !z && n == v; 4'd13: return z || n != v;
      default: return 1'b1;
    endcase
  endfunction
  function automatic logic [31:0] mk(int c, bit p, bit u, bit i, bit w,
                                     int b, int d, int hi, int lo);
    return {c[3:0], 3'b000, p, u, i, w, 1'b0, b[3:0], d[3:0], hi[3:0], 4'hD, lo[3:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model: response at least one cycle after the request is seen
  always @(posedge clk) begin
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= mdata(mem_addr);
        mem_err   <= merr(mem_addr);
        wcnt      <= 0;
        beats     <= beats + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  // Monitor: pops the expected item at each completion pulse
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, "R12 unexpected done", 32'h1, 32'h0);
      else begin
        exp_t e; string t;
        e = q.pop_front(); t = tq.pop_front();
        chk(result == 3'(e.res), {t, " result"}, 32'(result), 32'(e.res));
        chk(beats - beats_mark == e.nbeats, {t, " reads"}, 32'(beats - beats_mark), 32'(e.nbeats));
        chk(pair_we == e.pwe, {t, " pair_we"}, 32'(pair_we), 32'(e.pwe));
        if (e.pwe) begin
          chk(pair_sel == e.psel, {t, " pair_sel"}, 32'(pair_sel), 32'(e.psel));
          chk(pair_lo == e.lo, {t, " pair_lo"}, pair_lo, e.lo);
          chk(pair_hi == e.hi, {t, " pair_hi"}, pair_hi, e.hi);
        end
        chk(base_we == e.bwe, {t, " base_we"}, 32'(base_we), 32'(e.bwe));
        if (e.bwe) begin
          chk(base_sel == e.bsel, {t, " base_sel"}, 32'(base_sel), 32'(e.bsel));
          chk(base_data == e.bdata, {t, " base_data"}, base_data, e.bdata);
        end
      end
      beats_mark = beats;
    end else if (rst_n && (pair_we || base_we)) begin
      chk(1'b0, "R9 write outside completion", 32'(pair_we), 32'h0);
    end
  end

  // Driver: computes the expected outcome, pushes it, then issues the word
  task automatic run(input logic [31:0] ins, input logic [3:0] f, input bit aen,
                     input bit strict, input int l, input bit poke, input string tag);
    exp_t e;
    bit m, ill;
    logic [31:0] base, off, oa, acc;
    m    = (ins[27:25] == 3'b000) && !ins[20] && (ins[7:4] == 4'hD);
    ill  = !m || ins[12] || (ins[15:12] == 4'd14);
    base = rf[ins[19:16]];
    off  = ins[22] ? {24'h0, ins[11:8], ins[3:0]} : rf[ins[3:0]];
    oa   = ins[23] ? base + off : base - off;
    acc  = ins[24] ? oa : base;
    e = '{res: 0, nbeats: 0, pwe: 1'b0, psel: ins[15:12], lo: mdata(acc),
          hi: mdata(acc + 32'd4), bwe: 1'b0, bsel: ins[19:16], bdata: oa};
    if (ill) e.res = 4;
    else if (!cpass(ins[31:28], f)) e.res = 1;
    else if (aen && (acc[1:0] != 2'b00 || (strict && acc[2]))) e.res = 2;
    else if (merr(acc)) begin e.res = 3; e.nbeats = 1; end
    else if (merr(acc + 32'd4)) begin e.res = 3; e.nbeats = 2; end
    else begin e.nbeats = 2; e.pwe = 1'b1; e.bwe = !ins[24] || ins[21]; end
    q.push_back(e); tq.push_back(tag);
    lat = l;
    @(negedge clk);
    instr = ins; nzcv = f; align_en = aen; dw_strict = strict; start = 1'b1;
    #1 chk(claim == m, "R1 claim", 32'(claim), 32'(m));
    @(negedge clk);
    start = 1'b0;
    if (poke && !done) begin
      instr = mk(14, 1, 1, 1, 0, 2, 5, 0, 0);  // odd destination, would be illegal
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, {tag, " R12 idle after done"}, 32'({done, busy}), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000 + 32'(i) * 32'h10;
    rf[2] = 32'h100;  rf[5] = 32'h20;  rf[6] = 32'h200; rf[9] = 32'h18;
    rf[3] = 32'h102;  rf[7] = 32'h104; rf[10] = 32'hF000_0000;
    rf[11] = 32'hEFFF_FFF8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !busy && !mem_req && !pair_we && !base_we, "reset state",
        32'({done, busy, mem_req, pair_we, base_we}), 32'h0);

    run(mk(14, 1, 1, 0, 0, 2, 4, 0, 5), 4'h0, 1, 1, 0, 0, "R4 R5 R9 pre reg add");
    run(mk(14, 1, 0, 1, 1, 2, 6, 1, 0), 4'h0, 1, 1, 1, 0, "R4 R6 pre imm sub wb");
    run(mk(14, 0, 1, 0, 0, 6, 8, 0, 9), 4'h0, 1, 0, 2, 0, "R5 R6 post reg add");
    run(mk(15, 0, 0, 1, 1, 6, 0, 4'hA, 4'h8), 4'h0, 0, 0, 0, 0, "R3 R6 post imm sub");
    for (int c = 0; c < 16; c++) begin
      run(mk(c, 1, 1, 1, 0, 2, 2, 0, 8), 4'(c * 5 + 3), 0, 0, 0, 0, "R3 cond a");
      run(mk(c, 1, 1, 1, 0, 2, 2, 0, 8), 4'(c * 7 + 10), 0, 0, 0, 0, "R3 cond b");
    end
    run(mk(14, 1, 1, 1, 0, 3, 4, 0, 0), 4'h0, 1, 0, 0, 0, "R7 misaligned checked");
    run(mk(14, 1, 1, 1, 0, 3, 4, 0, 0), 4'h0, 0, 1, 0, 0, "R7 misaligned unchecked");
    run(mk(14, 1, 1, 1, 0, 7, 4, 0, 0), 4'h0, 1, 1, 0, 0, "R8 strict bit2");
    run(mk(14, 1, 1, 1, 0, 7, 4, 0, 0), 4'h0, 1, 0, 0, 0, "R8 non-strict bit2");
    run(mk(14, 1, 1, 1, 0, 7, 4, 0, 0), 4'h0, 0, 1, 0, 0, "R8 strict ignored unchecked");
    run(mk(0, 1, 1, 1, 0, 3, 4, 0, 0), 4'h0, 1, 0, 0, 0, "R3 skip beats align");
    run(mk(14, 1, 1, 1, 1, 10, 4, 0, 0), 4'h0, 0, 0, 1, 0, "R10 abort first read");
    run(mk(14, 1, 1, 1, 1, 11, 4, 0, 4), 4'h0, 0, 0, 2, 0, "R10 abort second read");
    run(mk(14, 1, 1, 1, 0, 2, 5, 0, 0), 4'h0, 0, 0, 0, 0, "R2 odd dest");
    run(mk(0, 1, 1, 1, 0, 2, 14, 0, 0), 4'h0, 0, 0, 0, 0, "R2 dest 14 before cond");
    run(mk(14, 1, 1, 1, 0, 2, 4, 0, 0) | 32'h0010_0000, 4'h0, 0, 0, 0, 0, "R1 bit20 set");
    run(mk(14, 1, 1, 1, 0, 2, 4, 0, 0) ^ 32'h0000_0060, 4'h0, 0, 0, 0, 0, "R1 wrong low pattern");
    run(mk(14, 1, 1, 1, 0, 2, 4, 0, 0) | 32'h0200_0000, 4'h0, 0, 0, 0, 0, "R1 wrong class bits");
    for (int l = 0; l < 5; l++)
      run(mk(14, 1, 1, 0, 1, 2, 10, 0, 5), 4'h0, 1, 1, l, 0, "R11 latency sweep");
    run(mk(14, 0, 0, 1, 0, 2, 12, 3, 0), 4'h0, 1, 1, 4, 1, "R12 start while busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule